// File: doc/BRIEF.md
# Software Flow-Control Engine for a UART Channel

This block runs in-band (Xon/Xoff) flow control for one serial channel. Every character the receiver delivers is compared against two programmable codes, one meaning "resume" and one meaning "stop". A received stop code can hold the local transmitter between characters, and a resume code releases it. The block also watches the receive FIFO occupancy and asks the transmitter to send a stop code to the far end when the FIFO is nearly full. It asks for a resume code once the FIFO has drained well below that point. A two-bit mode input sets which of these automatic actions are active. When neither is active, the host may request either code directly.

The block also decides whether a recognized flow-control character is written to the receive FIFO or removed from the stream. Whenever such a character arrives, it sets a sticky interrupt flag that a status read clears. The transmitter is outside this block. It samples `ins_req` and `tx_data_ok` when it reaches a character boundary, which it signals with `tx_boundary`. A pending inserted code is sent before any queued data character.

Top module: `sfc_flow_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `tx_data_ok`=1 and `ins_req`, `fifo_wr`, `irq_flag`, `xoff_sent` and `remote_paused` are all 0.
- R2: One cycle after a `rx_valid` strobe, `fifo_wr` is 1 and `fifo_wdata` holds the character. The exception is a character equal to `cfg_xon_code` or `cfg_xoff_code` while `cfg_strip`=1: that character gives `fifo_wr`=0.
- R3: In every mode, a received character equal to either flow-control code sets `irq_flag` on the next cycle. A `stat_rd` pulse clears the flag on the following cycle. A new code arriving in the same cycle as the read keeps the flag set.
- R4: In modes 2'b01 and 2'b11, a received stop code sets `remote_paused` two cycles after the strobe, and a received resume code clears it. `tx_data_ok` follows `!remote_paused` only at clock edges where `tx_boundary`=1 and otherwise holds its value.
- R5: In modes 2'b00 and 2'b10, received flow-control codes never set `remote_paused`, and `tx_data_ok` stays 1 across a boundary.
- R6: In modes 2'b10 and 2'b11, with `xoff_sent`=0, an `rx_fifo_level` of HI_MARK (240) or more causes the following. One cycle later `ins_req`=1 with `ins_code`=`cfg_xoff_code`, and `xoff_sent`=1.
- R7: While `xoff_sent`=1, a level at or above HI_MARK raises no further stop request. A level strictly between LO_MARK and HI_MARK raises no request at all.
- R8: With `xoff_sent`=1, a level of LO_MARK (128) or less causes the following. One cycle later `ins_req`=1 with `ins_code`=`cfg_xon_code`, and `xoff_sent`=0.
- R9: In mode 2'b00, a `host_send_xon` or `host_send_xoff` pulse gives `ins_req`=1 one cycle later with the matching code. If both are pulsed together, the stop code wins. In any other mode these host inputs are ignored.
- R10: `ins_req` stays high until a clock edge with `tx_boundary`=1, after which it is 0. While it is high, `tx_data_ok`=0, even if the transmitter is paused.
- R11: Leaving the automatic-receive modes clears `xoff_sent` on the next edge. Leaving the automatic-transmit modes clears `remote_paused` on the next edge, and `tx_data_ok` returns to 1 at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | 00 host, 01 auto transmit gating, 10 auto receive watermark, 11 both |
| cfg_strip | input | 1 | 1 = recognized flow codes are not written to the FIFO |
| cfg_xon_code | input | CHAR_W | Resume character code |
| cfg_xoff_code | input | CHAR_W | Stop character code |
| rx_valid | input | 1 | Received-character strobe |
| rx_data | input | CHAR_W | Received character |
| rx_fifo_level | input | LVL_W | Current receive FIFO occupancy |
| host_send_xon | input | 1 | Host request to send resume code |
| host_send_xoff | input | 1 | Host request to send stop code |
| stat_rd | input | 1 | Status read, clears `irq_flag` |
| tx_boundary | input | 1 | Transmitter is between characters this cycle |
| tx_data_ok | output | 1 | Transmitter may start a data character |
| ins_req | output | 1 | Inserted flow-control character pending |
| ins_code | output | CHAR_W | Code to insert |
| fifo_wr | output | 1 | Write strobe toward receive FIFO |
| fifo_wdata | output | CHAR_W | Data toward receive FIFO |
| irq_flag | output | 1 | Sticky flow-code-received flag |
| xoff_sent | output | 1 | A stop code has been requested and no resume yet |
| remote_paused | output | 1 | Far end has asked this transmitter to stop |

## Verification
The bench sweeps the FIFO level up and down across the full range several times and predicts each request from a small hysteresis model. A design that compared with the wrong inequality at 240 or 128 would fail here, as would one that resent the stop code every cycle above the high mark, or one that issued a resume without a prior stop. Every 8-bit character value is sent with stripping both off and on. This exposes a decoder that drops or keeps the wrong codes, or that sets the interrupt on ordinary data. The pause path is checked with long gaps before the boundary strobe, which catches gating that switches mid-character. Host requests are issued in each automatic mode, which catches a lockout that leaks through.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef enum logic [1:0] {
    FC_HOST      = 2'b00,
    FC_AUTO_TX   = 2'b01,
    FC_AUTO_RX   = 2'b10,
    FC_AUTO_BOTH = 2'b11
  } fc_mode_e;

  function automatic logic mode_gates_tx(input fc_mode_e m);
    return m[0];
  endfunction

  function automatic logic mode_watches_fifo(input fc_mode_e m);
    return m[1];
  endfunction

endpackage

// File: rtl/sfc_char_match.sv
module sfc_char_match #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_strip,
  input  logic [CHAR_W-1:0] cfg_xon_code,
  input  logic [CHAR_W-1:0] cfg_xoff_code,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              stat_rd,
  output logic              fifo_wr,
  output logic [CHAR_W-1:0] fifo_wdata,
  output logic              irq_flag,
  output logic              got_xon,
  output logic              got_xoff
);

  logic hit_xoff, hit_xon, hit_any;

  // Stop code takes precedence if both codes are programmed equal.
  assign hit_xoff = rx_valid && (rx_data == cfg_xoff_code);
  assign hit_xon  = rx_valid && (rx_data == cfg_xon_code) && !hit_xoff;
  assign hit_any  = hit_xon || hit_xoff;

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_wr    <= 1'b0;
      fifo_wdata <= '0;
      irq_flag   <= 1'b0;
      got_xon    <= 1'b0;
      got_xoff   <= 1'b0;
    end else begin
      fifo_wr  <= rx_valid && !(cfg_strip && hit_any);
      got_xon  <= hit_xon;
      got_xoff <= hit_xoff;
      if (rx_valid) fifo_wdata <= rx_data;
      if (hit_any)      irq_flag <= 1'b1;
      else if (stat_rd) irq_flag <= 1'b0;
    end
  end

  p_strip_r2: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && cfg_strip && (rx_data == cfg_xon_code || rx_data == cfg_xoff_code))
      |=> !fifo_wr);

  p_plain_write_r2: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_data != cfg_xon_code && rx_data != cfg_xoff_code)
      |=> (fifo_wr && fifo_wdata == $past(rx_data)));

  p_irq_set_r3: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && (rx_data == cfg_xon_code || rx_data == cfg_xoff_code)) |=> irq_flag);

  p_irq_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !rx_valid) |=> !irq_flag);

endmodule

// File: rtl/sfc_tx_gate.sv
module sfc_tx_gate (
  input  logic clk,
  input  logic rst,
  input  logic gate_en,
  input  logic got_xon,
  input  logic got_xoff,
  input  logic tx_boundary,
  output logic paused,
  output logic allow
);

  always_ff @(posedge clk) begin
    if (rst) begin
      paused <= 1'b0;
      allow  <= 1'b1;
    end else begin
      if (!gate_en)      paused <= 1'b0;
      else if (got_xoff) paused <= 1'b1;
      else if (got_xon)  paused <= 1'b0;
      // Only change permission between characters.
      if (tx_boundary) allow <= !paused;
    end
  end

  p_gate_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !tx_boundary |=> $stable(allow));

  p_gate_follow_r4: assert property (@(posedge clk) disable iff (rst)
    tx_boundary |=> (allow == !$past(paused)));

  p_no_pause_r5: assert property (@(posedge clk) disable iff (rst)
    !gate_en |=> !paused);

endmodule

// File: rtl/sfc_rx_watermark.sv
module sfc_rx_watermark #(
  parameter int LVL_W   = 9,
  parameter int HI_MARK = 240,
  parameter int LO_MARK = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wm_en,
  input  logic [LVL_W-1:0] level,
  output logic             sent_stop,
  output logic             want_xoff,
  output logic             want_xon
);

  localparam logic [LVL_W-1:0] HI_L = LVL_W'(HI_MARK);
  localparam logic [LVL_W-1:0] LO_L = LVL_W'(LO_MARK);

  assign want_xoff = wm_en && !sent_stop && (level >= HI_L);
  assign want_xon  = wm_en &&  sent_stop && (level <= LO_L);

  always_ff @(posedge clk) begin
    if (rst || !wm_en)  sent_stop <= 1'b0;
    else if (want_xoff) sent_stop <= 1'b1;
    else if (want_xon)  sent_stop <= 1'b0;
  end

  p_stop_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(sent_stop) |-> $past(level >= HI_L));

  p_resume_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(sent_stop) |-> $past(level <= LO_L || !wm_en));

  p_off_clears_r11: assert property (@(posedge clk) disable iff (rst)
    !wm_en |=> !sent_stop);

endmodule

// File: rtl/sfc_insert_slot.sv
module sfc_insert_slot #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_ok,
  input  logic              host_send_xon,
  input  logic              host_send_xoff,
  input  logic              want_xon,
  input  logic              want_xoff,
  input  logic [CHAR_W-1:0] cfg_xon_code,
  input  logic [CHAR_W-1:0] cfg_xoff_code,
  input  logic              tx_boundary,
  output logic              pend,
  output logic [CHAR_W-1:0] code
);

  logic load_xoff, load_xon;

  assign load_xoff = want_xoff || (host_ok && host_send_xoff);
  assign load_xon  = want_xon  || (host_ok && host_send_xon);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      code <= '0;
    end else if (load_xoff) begin
      pend <= 1'b1;
      code <= cfg_xoff_code;
    end else if (load_xon) begin
      pend <= 1'b1;
      code <= cfg_xon_code;
    end else if (tx_boundary) begin
      pend <= 1'b0;
    end
  end

  p_host_locked_r9: assert property (@(posedge clk) disable iff (rst)
    (!host_ok && !want_xon && !want_xoff && !pend) |=> !pend);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (pend && !tx_boundary) |=> pend);

  p_consume_r10: assert property (@(posedge clk) disable iff (rst)
    (pend && tx_boundary && !want_xon && !want_xoff &&
     !(host_ok && (host_send_xon || host_send_xoff))) |=> !pend);

endmodule

// File: rtl/sfc_flow_ctrl.sv
module sfc_flow_ctrl #(
  parameter int CHAR_W     = 8,
  parameter int FIFO_DEPTH = 256,
  parameter int HI_MARK    = 240,
  parameter int LO_MARK    = 128,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_strip,
  input  logic [CHAR_W-1:0] cfg_xon_code,
  input  logic [CHAR_W-1:0] cfg_xoff_code,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic [LVL_W-1:0]  rx_fifo_level,
  input  logic              host_send_xon,
  input  logic              host_send_xoff,
  input  logic              stat_rd,
  input  logic              tx_boundary,
  output logic              tx_data_ok,
  output logic              ins_req,
  output logic [CHAR_W-1:0] ins_code,
  output logic              fifo_wr,
  output logic [CHAR_W-1:0] fifo_wdata,
  output logic              irq_flag,
  output logic              xoff_sent,
  output logic              remote_paused
);
  import sfc_pkg::*;

  fc_mode_e mode;
  logic gate_en, wm_en, host_ok;
  logic got_xon, got_xoff;
  logic want_xon, want_xoff;
  logic gate_allow;

  assign mode    = fc_mode_e'(cfg_mode);
  assign gate_en = mode_gates_tx(mode);
  assign wm_en   = mode_watches_fifo(mode);
  assign host_ok = (mode == FC_HOST);

  sfc_char_match #(.CHAR_W(CHAR_W)) u_match (
    .clk(clk), .rst(rst), .cfg_strip(cfg_strip),
    .cfg_xon_code(cfg_xon_code), .cfg_xoff_code(cfg_xoff_code),
    .rx_valid(rx_valid), .rx_data(rx_data), .stat_rd(stat_rd),
    .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .irq_flag(irq_flag),
    .got_xon(got_xon), .got_xoff(got_xoff)
  );

  sfc_tx_gate u_gate (
    .clk(clk), .rst(rst), .gate_en(gate_en),
    .got_xon(got_xon), .got_xoff(got_xoff), .tx_boundary(tx_boundary),
    .paused(remote_paused), .allow(gate_allow)
  );

  sfc_rx_watermark #(.LVL_W(LVL_W), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)) u_wm (
    .clk(clk), .rst(rst), .wm_en(wm_en), .level(rx_fifo_level),
    .sent_stop(xoff_sent), .want_xoff(want_xoff), .want_xon(want_xon)
  );

  sfc_insert_slot #(.CHAR_W(CHAR_W)) u_slot (
    .clk(clk), .rst(rst), .host_ok(host_ok),
    .host_send_xon(host_send_xon), .host_send_xoff(host_send_xoff),
    .want_xon(want_xon), .want_xoff(want_xoff),
    .cfg_xon_code(cfg_xon_code), .cfg_xoff_code(cfg_xoff_code),
    .tx_boundary(tx_boundary), .pend(ins_req), .code(ins_code)
  );

  // An inserted code always goes ahead of queued data.
  assign tx_data_ok = gate_allow && !ins_req;

  p_insert_first_r10: assert property (@(posedge clk) disable iff (rst)
    ins_req |-> !tx_data_ok);

endmodule

// File: tb/sfc_flow_ctrl_tb_top.sv
`timescale 1ns/1ps
module sfc_flow_ctrl_tb_top;
  localparam int CW = 8, DEPTH = 256, HI = 240, LO = 128;
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [7:0] XON = 8'h11, XOFF = 8'h13;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, cfg_strip, rx_valid, host_send_xon, host_send_xoff, stat_rd, tx_boundary;
  logic [1:0] cfg_mode;
  logic [CW-1:0] cfg_xon_code, cfg_xoff_code, rx_data;
  logic [LW-1:0] rx_fifo_level;
  logic tx_data_ok, ins_req, fifo_wr, irq_flag, xoff_sent, remote_paused;
  logic [CW-1:0] ins_code, fifo_wdata;

  sfc_flow_ctrl #(.CHAR_W(CW), .FIFO_DEPTH(DEPTH), .HI_MARK(HI), .LO_MARK(LO)) dut_i (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_strip(cfg_strip),
    .cfg_xon_code(cfg_xon_code), .cfg_xoff_code(cfg_xoff_code),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_fifo_level(rx_fifo_level),
    .host_send_xon(host_send_xon), .host_send_xoff(host_send_xoff),
    .stat_rd(stat_rd), .tx_boundary(tx_boundary), .tx_data_ok(tx_data_ok),
    .ins_req(ins_req), .ins_code(ins_code), .fifo_wr(fifo_wr),
    .fifo_wdata(fifo_wdata), .irq_flag(irq_flag), .xoff_sent(xoff_sent),
    .remote_paused(remote_paused)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit m_sent = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] c);
    rx_valid = 1'b1; rx_data = c;
    cyc(1);
    rx_valid = 1'b0;
  endtask

  task automatic boundary();
    tx_boundary = 1'b1;
    cyc(1);
    tx_boundary = 1'b0;
  endtask

  task automatic wm_step(input int lvl);
    bit exp_req;
    logic [7:0] exp_code;
    rx_fifo_level = LW'(lvl);
    cyc(1);
    exp_req = 1'b0; exp_code = '0;
    if (!m_sent && lvl >= HI) begin exp_req = 1'b1; exp_code = XOFF; m_sent = 1'b1; end
    else if (m_sent && lvl <= LO) begin exp_req = 1'b1; exp_code = XON; m_sent = 1'b0; end
    if (exp_req && exp_code == XOFF)
      chk(ins_req == 1'b1, "R6 stop request at high mark", int'(ins_req), 1);
    else if (exp_req)
      chk(ins_req == 1'b1, "R8 resume request at low mark", int'(ins_req), 1);
    else
      chk(ins_req == 1'b0, "R7 no request", int'(ins_req), 0);
    chk(xoff_sent == m_sent, "R7 xoff_sent flag", int'(xoff_sent), int'(m_sent));
    if (exp_req) begin
      chk(ins_code == exp_code, "R6 R8 inserted code", int'(ins_code), int'(exp_code));
      boundary();
      chk(ins_req == 1'b0, "R10 consumed at boundary", int'(ins_req), 0);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      report();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_mode = 2'b00; cfg_strip = 1'b0;
    cfg_xon_code = XON; cfg_xoff_code = XOFF;
    rx_valid = 1'b0; rx_data = '0; rx_fifo_level = '0;
    host_send_xon = 1'b0; host_send_xoff = 1'b0; stat_rd = 1'b0; tx_boundary = 1'b0;
    cyc(3);
    chk(tx_data_ok == 1'b1 && ins_req == 1'b0, "R1 reset outputs", int'(tx_data_ok), 1);
    rst = 1'b0;
    cyc(1);
    chk(fifo_wr == 1'b0 && irq_flag == 1'b0, "R1 idle after reset", int'(fifo_wr), 0);
    chk(xoff_sent == 1'b0 && remote_paused == 1'b0, "R1 flags clear", int'(xoff_sent), 0);

    // Every character value, strip off then on.
    for (int s = 0; s < 2; s++) begin
      cfg_strip = s[0];
      for (int c = 0; c < 256; c++) begin
        bit hit, exp_wr;
        hit = (c == XON) || (c == XOFF);
        exp_wr = !(s[0] && hit);
        send_char(c[7:0]);
        chk(fifo_wr == exp_wr, "R2 fifo write", int'(fifo_wr), int'(exp_wr));
        if (exp_wr) chk(fifo_wdata == c[7:0], "R2 fifo data", int'(fifo_wdata), c);
        chk(irq_flag == hit, "R3 irq on flow code", int'(irq_flag), int'(hit));
        if (irq_flag) begin
          stat_rd = 1'b1; cyc(1); stat_rd = 1'b0;
          chk(irq_flag == 1'b0, "R3 irq cleared by read", int'(irq_flag), 0);
        end
      end
    end
    cfg_strip = 1'b0;
    send_char(XON);
    stat_rd = 1'b1; rx_valid = 1'b1; rx_data = XOFF; cyc(1);
    stat_rd = 1'b0; rx_valid = 1'b0;
    chk(irq_flag == 1'b1, "R3 set wins over read", int'(irq_flag), 1);
    stat_rd = 1'b1; cyc(1); stat_rd = 1'b0;
    chk(irq_flag == 1'b0, "R3 clear", int'(irq_flag), 0);

    // Transmit gating in mode 01.
    cfg_mode = 2'b01;
    send_char(XOFF); cyc(3);
    chk(remote_paused == 1'b1, "R4 pause on stop code", int'(remote_paused), 1);
    chk(tx_data_ok == 1'b1, "R4 no change before boundary", int'(tx_data_ok), 1);
    boundary();
    chk(tx_data_ok == 1'b0, "R4 gated at boundary", int'(tx_data_ok), 0);
    send_char(XON); cyc(2);
    chk(remote_paused == 1'b0, "R4 resume code", int'(remote_paused), 0);
    chk(tx_data_ok == 1'b0, "R4 held until boundary", int'(tx_data_ok), 0);
    boundary();
    chk(tx_data_ok == 1'b1, "R4 released at boundary", int'(tx_data_ok), 1);

    // No gating in modes 00 and 10.
    for (int m = 0; m < 3; m += 2) begin
      cfg_mode = m[1:0];
      send_char(XOFF); cyc(2);
      chk(remote_paused == 1'b0, "R5 no pause", int'(remote_paused), 0);
      boundary();
      chk(tx_data_ok == 1'b1, "R5 data still allowed", int'(tx_data_ok), 1);
    end

    // Leaving auto transmit mode releases the pause.
    cfg_mode = 2'b11;
    send_char(XOFF); cyc(2); boundary();
    chk(tx_data_ok == 1'b0, "R4 gated in mode 11", int'(tx_data_ok), 0);
    cfg_mode = 2'b00; cyc(1);
    chk(remote_paused == 1'b0, "R11 pause cleared", int'(remote_paused), 0);
    chk(tx_data_ok == 1'b0, "R11 waits for boundary", int'(tx_data_ok), 0);
    boundary();
    chk(tx_data_ok == 1'b1, "R11 released", int'(tx_data_ok), 1);

    // Host commands in mode 00.
    host_send_xoff = 1'b1; cyc(1); host_send_xoff = 1'b0;
    chk(ins_req == 1'b1 && ins_code == XOFF, "R9 host stop", int'(ins_code), int'(XOFF));
    chk(tx_data_ok == 1'b0, "R10 insert ahead of data", int'(tx_data_ok), 0);
    cyc(5);
    chk(ins_req == 1'b1, "R10 held until boundary", int'(ins_req), 1);
    boundary();
    chk(ins_req == 1'b0 && tx_data_ok == 1'b1, "R10 consumed", int'(ins_req), 0);
    host_send_xon = 1'b1; cyc(1); host_send_xon = 1'b0;
    chk(ins_req == 1'b1 && ins_code == XON, "R9 host resume", int'(ins_code), int'(XON));
    boundary();
    host_send_xon = 1'b1; host_send_xoff = 1'b1; cyc(1);
    host_send_xon = 1'b0; host_send_xoff = 1'b0;
    chk(ins_code == XOFF, "R9 stop wins", int'(ins_code), int'(XOFF));
    boundary();

    // Host commands locked out in automatic modes.
    for (int m = 1; m < 4; m++) begin
      cfg_mode = m[1:0];
      host_send_xon = 1'b1; cyc(1); host_send_xon = 1'b0;
      chk(ins_req == 1'b0, "R9 host resume ignored", int'(ins_req), 0);
      host_send_xoff = 1'b1; cyc(1); host_send_xoff = 1'b0;
      chk(ins_req == 1'b0, "R9 host stop ignored", int'(ins_req), 0);
    end

    // Insert still requested while transmitter is paused.
    cfg_mode = 2'b11;
    send_char(XOFF); cyc(2); boundary();
    rx_fifo_level = LW'(HI); cyc(1);
    chk(ins_req == 1'b1 && ins_code == XOFF, "R10 insert while paused", int'(ins_req), 1);
    boundary();
    rx_fifo_level = '0; cyc(1);
    chk(ins_req == 1'b1 && ins_code == XON, "R8 resume request", int'(ins_code), int'(XON));
    boundary();
    cfg_mode = 2'b00; cyc(1); boundary();

    // Level sweeps in mode 10.
    cfg_mode = 2'b10; m_sent = 1'b0;
    for (int l = 0; l <= DEPTH; l++) wm_step(l);
    for (int l = DEPTH; l >= 0; l--) wm_step(l);
    for (int l = 0; l <= 200; l++) wm_step(l);
    for (int l = 200; l >= 0; l--) wm_step(l);
    for (int l = 100; l <= 250; l += 3) wm_step(l);
    cfg_mode = 2'b00; cyc(1);
    chk(xoff_sent == 1'b0, "R11 flag cleared leaving mode", int'(xoff_sent), 0);
    m_sent = 1'b0;
    cfg_mode = 2'b10;
    wm_step(250);
    wm_step(245);

    done = 1'b1;
    report();
    $finish;
  end
endmodule